// File: doc/BRIEF.md
# Programmable FIFO Threshold Flag Generator

This block produces three active-low status flags for a FIFO: almost-empty, half-full and almost-full. It does not hold the FIFO storage or pointers. The FIFO supplies its current word count on an occupancy input, and the block compares that count against thresholds every clock. Each flag is registered, so the flag reflects the occupancy that was sampled at the previous rising edge.

Two offset registers set the programmable thresholds. The empty offset n sets the almost-empty threshold and the full offset m sets the almost-full threshold. Both registers load through the same 12-bit data bus. A one-bit pointer decides which register the next load writes, and it toggles after every load. Whenever the load strobe and the write enable are both low at a rising edge, one register is written.

A mode input chooses between standard timing and first-word-fall-through timing. In first-word-fall-through timing the FIFO keeps one extra word in its output register, so every threshold is one word higher. The depth and the default offsets are parameters.

Top module: `fifo_thr_flags`

## Requirements
- R1: While rst_n is low and after it is released, almost_empty_n is 0, half_full_n is 1 and almost_full_n is 1 until the first clock edge. Reset restores both offsets to their defaults (DEF_EMPTY_OFS, DEF_FULL_OFS) and points the load pointer at the empty offset.
- R2: An offset register is written on a rising edge only when load_n = 0 and wr_en_n = 0 at that edge. The value written is ofs_data[11:0]. At any other edge neither offset changes.
- R3: Within a load session, successive loads write the empty offset, then the full offset, then the empty offset again, and keep alternating.
- R4: While load_n = 1 the load pointer keeps its position. A later session therefore continues the alternation from where the previous one stopped.
- R5: In standard mode (fwft_mode = 0), almost_empty_n is 0 while occupancy ≤ n and 1 once occupancy ≥ n+1.
- R6: In first-word-fall-through mode (fwft_mode = 1), almost_empty_n is 0 while occupancy ≤ n+1 and 1 once occupancy ≥ n+2.
- R7: half_full_n is 0 when occupancy ≥ DEPTH/2+1 in standard mode, or ≥ DEPTH/2+2 in first-word-fall-through mode. It is 1 otherwise.
- R8: almost_full_n is 0 when occupancy ≥ DEPTH−m in standard mode, or ≥ DEPTH+1−m in first-word-fall-through mode. It is 1 otherwise. An offset larger than DEPTH keeps almost_full_n at 0.
- R9: The flags are registered. A change on occupancy, fwft_mode or an offset shows on the flags only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwft_mode | input | 1 | 1 selects first-word-fall-through thresholds |
| wr_en_n | input | 1 | Active-low write enable |
| load_n | input | 1 | Active-low offset load strobe |
| ofs_data | input | OFS_W (12) | Offset value taken from the low data-input bits |
| occupancy | input | CNT_W | Current number of stored words, 0 to DEPTH+1 |
| almost_empty_n | output | 1 | Programmable almost-empty flag, active low |
| half_full_n | output | 1 | Half-full flag, active low |
| almost_full_n | output | 1 | Programmable almost-full flag, active low |

## Verification
The bench builds the block with DEPTH = 64, an empty-offset default of 5 and a full-offset default of 9. Because the two defaults differ, a swapped register or a wrong reset value shows on the flags. At depth 64 every occupancy from 0 to DEPTH+1 can be swept in both modes after each load session, so all three threshold edges are crossed many times. A 12-bit offset larger than the depth can also be loaded, which drives both programmable flags to their saturated state.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  typedef struct packed {
    logic ae_n;
    logic hf_n;
    logic af_n;
  } flag_vec_t;

  localparam int NUM_FLAGS = 3;
  localparam int IDX_AE = 0;
  localparam int IDX_HF = 1;
  localparam int IDX_AF = 2;

endpackage

// File: rtl/offset_loader.sv
module offset_loader
  import fifo_thr_pkg::*;
#(
  parameter int OFS_W         = 12,
  parameter int DEF_EMPTY_OFS = 31,
  parameter int DEF_FULL_OFS  = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             wr_en_n,
  input  logic [OFS_W-1:0] ofs_data,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output ofs_sel_e         sel
);

  localparam logic [OFS_W-1:0] RST_EMPTY = OFS_W'(DEF_EMPTY_OFS);
  localparam logic [OFS_W-1:0] RST_FULL  = OFS_W'(DEF_FULL_OFS);

  logic             load_act;
  logic [OFS_W-1:0] empty_nxt;
  logic [OFS_W-1:0] full_nxt;
  ofs_sel_e         sel_nxt;

  assign load_act = ~load_n & ~wr_en_n;

  // next-state: the selected register takes the bus, pointer flips
  always_comb begin
    empty_nxt = empty_ofs;
    full_nxt  = full_ofs;
    sel_nxt   = sel;
    if (load_act) begin
      if (sel == SEL_EMPTY) begin
        empty_nxt = ofs_data;
        sel_nxt   = SEL_FULL;
      end else begin
        full_nxt  = ofs_data;
        sel_nxt   = SEL_EMPTY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_ofs <= RST_EMPTY;
      full_ofs  <= RST_FULL;
      sel       <= SEL_EMPTY;
    end else if (load_act) begin
      empty_ofs <= empty_nxt;
      full_ofs  <= full_nxt;
      sel       <= sel_nxt;
    end
  end

endmodule

// File: rtl/ge_cmp.sv
module ge_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         ge
);

  assign ge = (lhs >= rhs);

endmodule

// File: rtl/threshold_calc.sv
module threshold_calc
  import fifo_thr_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CNT_W = 9,
  parameter int OFS_W = 12
) (
  input  logic [CNT_W-1:0] occupancy,
  input  logic             fwft_mode,
  input  logic [OFS_W-1:0] empty_ofs,
  input  logic [OFS_W-1:0] full_ofs,
  output flag_vec_t        flags_nxt
);

  // wide enough for occupancy + offset and for DEPTH + 2 without wrap
  localparam int BASE_W = (OFS_W > CNT_W) ? OFS_W : CNT_W;
  localparam int SW     = BASE_W + 2;
  localparam logic [SW-1:0] DEPTH_V = SW'(DEPTH);
  localparam logic [SW-1:0] HALF_V  = SW'(DEPTH / 2 + 1);

  logic [SW-1:0] occ_w;
  logic [SW-1:0] mode_w;
  logic [SW-1:0] lhs [NUM_FLAGS];
  logic [SW-1:0] rhs [NUM_FLAGS];
  logic          ge  [NUM_FLAGS];

  assign occ_w  = SW'(occupancy);
  assign mode_w = SW'(fwft_mode);

  // almost-empty releases at n+1 (+1 in fall-through mode)
  assign lhs[IDX_AE] = occ_w;
  assign rhs[IDX_AE] = SW'(empty_ofs) + SW'(1) + mode_w;
  // half-full asserts at DEPTH/2+1 (+1 in fall-through mode)
  assign lhs[IDX_HF] = occ_w;
  assign rhs[IDX_HF] = HALF_V + mode_w;
  // almost-full asserts at DEPTH-m (+1): written as occ+m >= DEPTH(+1)
  assign lhs[IDX_AF] = occ_w + SW'(full_ofs);
  assign rhs[IDX_AF] = DEPTH_V + mode_w;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cmp
    ge_cmp #(.W(SW)) u_cmp (
      .lhs (lhs[i]),
      .rhs (rhs[i]),
      .ge  (ge[i])
    );
  end

  always_comb begin
    flags_nxt.ae_n = ge[IDX_AE];
    flags_nxt.hf_n = ~ge[IDX_HF];
    flags_nxt.af_n = ~ge[IDX_AF];
  end

endmodule

// File: rtl/fifo_thr_flags.sv
module fifo_thr_flags
  import fifo_thr_pkg::*;
#(
  parameter int DEPTH         = 256,
  parameter int OFS_W         = 12,
  parameter int DEF_EMPTY_OFS = 31,
  parameter int DEF_FULL_OFS  = 31,
  parameter int CNT_W         = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwft_mode,
  input  logic             wr_en_n,
  input  logic             load_n,
  input  logic [OFS_W-1:0] ofs_data,
  input  logic [CNT_W-1:0] occupancy,
  output logic             almost_empty_n,
  output logic             half_full_n,
  output logic             almost_full_n
);

  localparam flag_vec_t FLAGS_RST = '{ae_n: 1'b0, hf_n: 1'b1, af_n: 1'b1};

  logic [OFS_W-1:0] empty_ofs;
  logic [OFS_W-1:0] full_ofs;
  ofs_sel_e         sel;
  flag_vec_t        flags_nxt;
  flag_vec_t        flags_q;

  offset_loader #(
    .OFS_W         (OFS_W),
    .DEF_EMPTY_OFS (DEF_EMPTY_OFS),
    .DEF_FULL_OFS  (DEF_FULL_OFS)
  ) u_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .wr_en_n   (wr_en_n),
    .ofs_data  (ofs_data),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .sel       (sel)
  );

  threshold_calc #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .OFS_W (OFS_W)
  ) u_calc (
    .occupancy (occupancy),
    .fwft_mode (fwft_mode),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .flags_nxt (flags_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= FLAGS_RST;
    else        flags_q <= flags_nxt;
  end

  assign almost_empty_n = flags_q.ae_n;
  assign half_full_n    = flags_q.hf_n;
  assign almost_full_n  = flags_q.af_n;

endmodule

// File: rtl/fifo_thr_flags_chk.sv
module fifo_thr_flags_chk
  import fifo_thr_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int OFS_W = 12,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en_n,
  input logic             load_n,
  input logic [OFS_W-1:0] ofs_data,
  input logic [CNT_W-1:0] occupancy,
  input logic             almost_empty_n,
  input logic             half_full_n,
  input logic             almost_full_n,
  input logic [OFS_W-1:0] empty_ofs,
  input logic [OFS_W-1:0] full_ofs,
  input ofs_sel_e         sel
);

  logic load_act;
  assign load_act = !load_n && !wr_en_n;

  assert_load_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_act && sel == SEL_EMPTY) |=> (empty_ofs == $past(ofs_data)) && $stable(full_ofs));

  assert_no_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_act |=> $stable(empty_ofs) && $stable(full_ofs));

  assert_load_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_act && sel == SEL_FULL) |=> (full_ofs == $past(ofs_data)) && $stable(empty_ofs));

  assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_act |=> sel != $past(sel));

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> $stable(sel));

  assert_empty_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |=> !almost_empty_n);

  assert_hf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(occupancy) <= DEPTH / 2) |=> half_full_n);

  assert_af_over_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(occupancy) > DEPTH) |=> !almost_full_n);

endmodule

bind fifo_thr_flags fifo_thr_flags_chk #(
  .DEPTH (DEPTH),
  .OFS_W (OFS_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en_n        (wr_en_n),
  .load_n         (load_n),
  .ofs_data       (ofs_data),
  .occupancy      (occupancy),
  .almost_empty_n (almost_empty_n),
  .half_full_n    (half_full_n),
  .almost_full_n  (almost_full_n),
  .empty_ofs      (empty_ofs),
  .full_ofs       (full_ofs),
  .sel            (sel)
);

// File: tb/tb_fifo_thr_flags.sv
`timescale 1ns/1ps
module tb_fifo_thr_flags;

  localparam int DEPTH = 64;
  localparam int OFS_W = 12;
  localparam int DEF_E = 5;
  localparam int DEF_F = 9;
  localparam int CNT_W = $clog2(DEPTH + 2);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             fwft_mode;
  logic             wr_en_n;
  logic             load_n;
  logic [OFS_W-1:0] ofs_data;
  logic [CNT_W-1:0] occupancy;
  logic             almost_empty_n;
  logic             half_full_n;
  logic             almost_full_n;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_n, exp_m;
  bit exp_sel_full;

  always #10 clk = ~clk;

  fifo_thr_flags #(
    .DEPTH         (DEPTH),
    .OFS_W         (OFS_W),
    .DEF_EMPTY_OFS (DEF_E),
    .DEF_FULL_OFS  (DEF_F)
  ) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .fwft_mode      (fwft_mode),
    .wr_en_n        (wr_en_n),
    .load_n         (load_n),
    .ofs_data       (ofs_data),
    .occupancy      (occupancy),
    .almost_empty_n (almost_empty_n),
    .half_full_n    (half_full_n),
    .almost_full_n  (almost_full_n)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (n=%0d m=%0d occ=%0d fwft=%b)",
               req, what, act, exp, exp_n, exp_m, occupancy, fwft_mode);
    end
  endtask

  function automatic logic m_ae(int occ, int f);
    return (occ >= exp_n + 1 + f);
  endfunction
  function automatic logic m_hf(int occ, int f);
    return !(occ >= DEPTH / 2 + 1 + f);
  endfunction
  function automatic logic m_af(int occ, int f);
    return !(occ + exp_m >= DEPTH + f);
  endfunction

  task automatic apply_occ(int occ);
    @(negedge clk);
    occupancy = CNT_W'(occ);
    @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic check_flags(int occ);
    int f = int'(fwft_mode);
    chk(f ? "R6" : "R5", "almost_empty_n", almost_empty_n, m_ae(occ, f));
    chk("R7", "half_full_n", half_full_n, m_hf(occ, f));
    chk("R8", "almost_full_n", almost_full_n, m_af(occ, f));
  endtask

  task automatic sweep(bit mode);
    @(negedge clk);
    fwft_mode = mode;
    for (int o = 0; o <= DEPTH + 1; o++) begin
      apply_occ(o);
      check_flags(o);
    end
  endtask

  task automatic load_word(int v);
    @(negedge clk);
    load_n = 1'b0; wr_en_n = 1'b0; ofs_data = OFS_W'(v);
    @(posedge clk);
    @(negedge clk);
    load_n = 1'b1; wr_en_n = 1'b1;
    if (exp_sel_full) exp_m = v; else exp_n = v;
    exp_sel_full = !exp_sel_full;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    chk("R1", "almost_empty_n in reset", almost_empty_n, 1'b0);
    chk("R1", "half_full_n in reset", half_full_n, 1'b1);
    chk("R1", "almost_full_n in reset", almost_full_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    exp_n = DEF_E; exp_m = DEF_F; exp_sel_full = 1'b0;
  endtask

  task automatic t_reset_state();
    occupancy = '0; fwft_mode = 1'b0; wr_en_n = 1'b1; load_n = 1'b1; ofs_data = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    do_reset();
    #2;
    chk("R1", "almost_empty_n after release", almost_empty_n, 1'b0);
    chk("R1", "half_full_n after release", half_full_n, 1'b1);
    chk("R1", "almost_full_n after release", almost_full_n, 1'b1);
    // defaults observed through the thresholds: n=5, m=9
    apply_occ(DEF_E);     chk("R1", "ae at default n", almost_empty_n, 1'b0);
    apply_occ(DEF_E + 1); chk("R1", "ae above default n", almost_empty_n, 1'b1);
    apply_occ(DEPTH - DEF_F - 1); chk("R1", "af below default", almost_full_n, 1'b1);
    apply_occ(DEPTH - DEF_F);     chk("R1", "af at default", almost_full_n, 1'b0);
  endtask

  task automatic t_sweep_defaults();
    sweep(1'b0);
    sweep(1'b1);
  endtask

  task automatic t_registered();
    @(negedge clk);
    fwft_mode = 1'b0;
    apply_occ(0);
    @(negedge clk);
    occupancy = CNT_W'(DEPTH);
    #2;
    chk("R9", "ae held before edge", almost_empty_n, 1'b0);
    chk("R9", "hf held before edge", half_full_n, 1'b1);
    chk("R9", "af held before edge", almost_full_n, 1'b1);
    @(posedge clk);
    #2;
    chk("R9", "ae after edge", almost_empty_n, 1'b1);
    chk("R9", "hf after edge", half_full_n, 1'b0);
    chk("R9", "af after edge", almost_full_n, 1'b0);
    // mode change alone only acts after an edge
    apply_occ(DEPTH / 2 + 1);
    chk("R7", "hf std at D/2+1", half_full_n, 1'b0);
    @(negedge clk);
    fwft_mode = 1'b1;
    #2;
    chk("R9", "hf held on mode change", half_full_n, 1'b0);
    @(posedge clk);
    #2;
    chk("R7", "hf fwft at D/2+1", half_full_n, 1'b1);
  endtask

  task automatic t_load_order();
    load_word(20);
    load_word(40);
    load_word(3);
    chk("R3", "third load went to empty offset", (exp_n == 3 && exp_m == 40), 1'b1);
    sweep(1'b0);
    sweep(1'b1);
  endtask

  task automatic t_resume();
    load_word(12);
    repeat (4) @(negedge clk);
    load_word(17);
    sweep(1'b0);
    sweep(1'b1);
  endtask

  task automatic t_ignored();
    @(negedge clk);
    load_n = 1'b0; wr_en_n = 1'b1; ofs_data = OFS_W'(50);
    @(negedge clk);
    load_n = 1'b1; wr_en_n = 1'b0; ofs_data = OFS_W'(50);
    @(negedge clk);
    wr_en_n = 1'b1;
    sweep(1'b0);
    load_word(0);
    sweep(1'b0);
    sweep(1'b1);
  endtask

  task automatic t_reset_restore();
    do_reset();
    load_word(2);
    sweep(1'b0);
    sweep(1'b1);
  endtask

  task automatic t_extremes();
    load_word(4000);
    load_word(100);
    sweep(1'b0);
    sweep(1'b1);
    apply_occ(DEPTH + 1);
    chk("R5", "ae held low by huge n", almost_empty_n, 1'b0);
    chk("R8", "af held low by m>DEPTH", almost_full_n, 1'b0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_sweep_defaults();
    t_registered();
    t_load_order();
    t_resume();
    t_ignored();
    t_reset_restore();
    t_extremes();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule